// File: doc/BRIEF.md
# Control Endpoint Zero IN Data-Stage Engine

This block runs the device-to-host half of the data stage of a control transfer on endpoint zero. Firmware pushes the bytes of one packet into a local buffer through a byte write port. It then pulses an arm strobe to mark the packet as ready to go. Each decoded IN token from the host gets one of two answers: the armed packet, streamed out one byte per beat, or a NAK pulse if nothing is armed. The host's ACK retires the packet. A sticky completion flag then tells firmware it may load the next one, so only one packet is in flight at a time.

A packet that is never acknowledged, because the handshake timed out, stays armed and is sent again unchanged on the next IN token. Firmware ends the stage with a short packet, or with a zero-length packet when the total is a whole number of full packets. The engine emits a zero-length packet as a single marker beat. An OUT token seen while idle means the host has moved on to the status stage, and a flag reports this. A SETUP token flushes the buffer and resets the stage.

Both byte interfaces use valid/ready. A byte moves only on a cycle where both valid and ready are high. The write port drops ready only when the buffer holds a full, unarmed packet. While a packet is armed, write beats are accepted and dropped. The transmit port holds valid, data and the last/zero-length marks steady for as long as ready stays low.

Top module: `ep0_in_stage`

## Requirements
- R1: After reset: pkt_armed, tx_done, wr_err, status_stage, irq, nak and tx_valid are 0, and wr_ready is 1.
- R2: An IN token sampled while no packet is armed, or while in the status stage, causes nak to be 1 for exactly the next cycle, and tx_valid stays 0.
- R3: An IN token sampled while a packet of N>0 bytes is armed raises tx_valid from the next cycle. The N bytes come out in write order, with tx_last=1 only on byte N.
- R4: While tx_valid=1 and tx_ready=0, the next cycle keeps tx_valid=1 with tx_data, tx_last and tx_zlp unchanged.
- R5: A packet armed with no bytes written goes out as one beat with tx_zlp=1 and tx_last=1.
- R6: An ACK after the final beat sets tx_done and clears pkt_armed on the next cycle.
- R7: A handshake timeout after the final beat leaves pkt_armed=1 and tx_done=0. The next IN token resends the same bytes.
- R8: tx_done stays set until fw_clr_done is pulsed.
- R9: irq equals tx_done AND irq_en.
- R10: A write beat while a packet is armed is accepted but not stored, and it sets wr_err. The resent packet still shows the original bytes.
- R11: With MAX_PKT bytes stored and no packet armed, wr_ready is 0 and no more bytes are stored.
- R12: An OUT token sampled while idle sets status_stage on the next cycle.
- R13: A SETUP token clears pkt_armed, status_stage and wr_err, empties the buffer and ends any transmission in progress. A following IN token is answered with NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Firmware byte write valid |
| wr_ready | output | 1 | Write port can take a byte |
| wr_data | input | 8 | Firmware byte |
| fw_arm | input | 1 | Pulse: mark the loaded packet ready to send |
| fw_clr_done | input | 1 | Pulse: clear tx_done |
| irq_en | input | 1 | Interrupt enable |
| tok_in | input | 1 | Decoded IN token strobe |
| tok_out | input | 1 | Decoded OUT token strobe |
| tok_setup | input | 1 | Decoded SETUP token strobe |
| hs_ack | input | 1 | Host ACK handshake strobe |
| hs_timeout | input | 1 | Handshake timeout strobe |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat is a zero-length packet marker |
| nak | output | 1 | One-cycle NAK answer |
| pkt_armed | output | 1 | A packet is armed |
| tx_done | output | 1 | Sticky transmit-complete flag |
| wr_err | output | 1 | Sticky write-while-armed error |
| status_stage | output | 1 | OUT token seen; status stage entered |
| irq | output | 1 | Interrupt request |

## Verification
Random packet lengths from zero to a full buffer, sent under random transmit back-pressure, check that byte order, last-beat marking and the hold rule are independent of length and stall pattern. Randomly injected timeouts before the ACK separate a correct retransmit from one that skips or rewinds wrongly. Directed cases cover these: an IN token with nothing armed, a full buffer pushed with one extra byte, a zero-length packet, writes while armed, an OUT token, and a SETUP token in the middle of a send. Each shows one control rule taking precedence over the data path.

// File: rtl/ep0_in_pkg.sv
package ep0_in_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_STATUS = 2'd3
  } ep0_state_t;
endpackage

// File: rtl/ep0_in_fifo.sv
module ep0_in_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_rewind,
  input  logic          rd_adv,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          zero_len,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] fill;
  logic [CW-1:0] rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[fill[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (flush)  fill <= '0;
    else if (wr_en)  fill <= fill + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rptr <= '0;
    else if (flush || rd_rewind) rptr <= '0;
    else if (rd_adv)             rptr <= rptr + 1'b1;
  end

  assign rd_data  = mem[rptr[AW-1:0]];
  assign full     = (fill == CW'(DEPTH));
  assign zero_len = (fill == '0);
  assign rd_last  = zero_len || (rptr == fill - CW'(1));

  // R11
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R3
  fifo_rptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv && !flush && !rd_rewind |-> rptr < fill);
endmodule

// File: rtl/ep0_in_ctrl.sv
module ep0_in_ctrl
  import ep0_in_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_in,
  input  logic          tok_out,
  input  logic          tok_setup,
  input  logic          hs_ack,
  input  logic          hs_timeout,
  input  logic          armed,
  input  logic          rd_last,
  input  logic          zero_len,
  input  logic [DW-1:0] rd_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          nak,
  output logic          rd_rewind,
  output logic          rd_adv,
  output logic          ack_evt,
  output logic          out_evt
);
  ep0_state_t state, state_nx;
  logic beat;
  logic start;

  assign tx_valid  = (state == ST_SEND);
  assign tx_data   = zero_len ? '0 : rd_data;
  assign tx_last   = tx_valid && rd_last;
  assign tx_zlp    = tx_valid && zero_len;
  assign beat      = tx_valid && tx_ready;
  assign rd_adv    = beat && !zero_len && !tok_setup;
  assign start     = (state == ST_IDLE) && tok_in && armed && !tok_setup;
  assign rd_rewind = start;
  assign ack_evt   = (state == ST_WAIT) && hs_ack && !tok_setup;
  assign out_evt   = (state == ST_IDLE) && tok_out && !tok_in && !tok_setup;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (start)        state_nx = ST_SEND;
        else if (out_evt) state_nx = ST_STATUS;
      end
      ST_SEND:   if (beat && rd_last) state_nx = ST_WAIT;
      ST_WAIT:   if (hs_ack || hs_timeout) state_nx = ST_IDLE;
      ST_STATUS: state_nx = ST_STATUS;
      default:   state_nx = ST_IDLE;
    endcase
    if (tok_setup) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      nak   <= 1'b0;
    end else begin
      state <= state_nx;
      nak   <= tok_in && !tok_setup &&
               ((state == ST_STATUS) || ((state == ST_IDLE) && !armed));
    end
  end

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tok_setup |=>
      tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp));

  // R2
  nak_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> !tx_valid);

  // R5
  zlp_single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> tx_last);
endmodule

// File: rtl/ep0_in_flags.sv
module ep0_in_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fw_arm,
  input  logic fw_clr_done,
  input  logic irq_en,
  input  logic wr_beat,
  input  logic tok_setup,
  input  logic ack_evt,
  input  logic out_evt,
  output logic armed,
  output logic done,
  output logic err,
  output logic status_stage,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      status_stage <= 1'b0;
    end else begin
      if (tok_setup || ack_evt) armed <= 1'b0;
      else if (fw_arm)          armed <= 1'b1;

      if (ack_evt)          done <= 1'b1;
      else if (fw_clr_done) done <= 1'b0;

      if (tok_setup)             err <= 1'b0;
      else if (wr_beat && armed) err <= 1'b1;

      if (tok_setup)    status_stage <= 1'b0;
      else if (out_evt) status_stage <= 1'b1;
    end
  end

  assign irq = done && irq_en;

  // R6
  done_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> done && !armed);

  // R13
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> !armed && !status_stage && !err);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fw_clr_done |=> done);
endmodule

// File: rtl/ep0_in_stage.sv
module ep0_in_stage #(
  parameter int MAX_PKT = 64,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          fw_arm,
  input  logic          fw_clr_done,
  input  logic          irq_en,
  input  logic          tok_in,
  input  logic          tok_out,
  input  logic          tok_setup,
  input  logic          hs_ack,
  input  logic          hs_timeout,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic          nak,
  output logic          pkt_armed,
  output logic          tx_done,
  output logic          wr_err,
  output logic          status_stage,
  output logic          irq
);
  logic          full, zero_len, rd_last, rd_rewind, rd_adv;
  logic          ack_evt, out_evt, wr_beat, wr_en;
  logic [DW-1:0] rd_data;

  assign wr_ready = pkt_armed || !full;
  assign wr_beat  = wr_valid && wr_ready;
  assign wr_en    = wr_beat && !pkt_armed && !tok_setup;

  ep0_in_fifo #(.DEPTH(MAX_PKT), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tok_setup || ack_evt),
    .wr_en(wr_en), .wr_data(wr_data), .rd_rewind(rd_rewind), .rd_adv(rd_adv),
    .rd_data(rd_data), .rd_last(rd_last), .zero_len(zero_len), .full(full)
  );

  ep0_in_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .tok_out(tok_out),
    .tok_setup(tok_setup), .hs_ack(hs_ack), .hs_timeout(hs_timeout),
    .armed(pkt_armed), .rd_last(rd_last), .zero_len(zero_len),
    .rd_data(rd_data), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp), .nak(nak),
    .rd_rewind(rd_rewind), .rd_adv(rd_adv), .ack_evt(ack_evt), .out_evt(out_evt)
  );

  ep0_in_flags u_flags (
    .clk(clk), .rst_n(rst_n), .fw_arm(fw_arm), .fw_clr_done(fw_clr_done),
    .irq_en(irq_en), .wr_beat(wr_beat), .tok_setup(tok_setup),
    .ack_evt(ack_evt), .out_evt(out_evt), .armed(pkt_armed), .done(tx_done),
    .err(wr_err), .status_stage(status_stage), .irq(irq)
  );

  // R10
  armed_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && pkt_armed |-> wr_ready && !wr_en);
endmodule

// File: tb/test_ep0_in_stage.sv
module test_ep0_in_stage;
  localparam int MAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, fw_arm = 0, fw_clr_done = 0, irq_en = 0;
  logic tok_in = 0, tok_out = 0, tok_setup = 0, hs_ack = 0, hs_timeout = 0;
  logic tx_ready = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, tx_valid, tx_last, tx_zlp, nak;
  logic pkt_armed, tx_done, wr_err, status_stage, irq;
  logic [7:0] tx_data;

  int total = 0, bad = 0;
  byte unsigned exp_b [MAX];
  int exp_len = 0;
  bit m_armed = 0;

  always #10 clk = ~clk;

  ep0_in_stage #(.MAX_PKT(MAX), .DW(8)) i_ep0_in_stage (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fw_arm(fw_arm), .fw_clr_done(fw_clr_done),
    .irq_en(irq_en), .tok_in(tok_in), .tok_out(tok_out), .tok_setup(tok_setup),
    .hs_ack(hs_ack), .hs_timeout(hs_timeout), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp),
    .nak(nak), .pkt_armed(pkt_armed), .tx_done(tx_done), .wr_err(wr_err),
    .status_stage(status_stage), .irq(irq)
  );

  function automatic bit exp_irq(bit d, bit e);
    return d & e;
  endfunction

  function automatic bit exp_last(int idx, int len);
    return idx == len - 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input byte unsigned b);
    wr_valid = 1; wr_data = b;
    if (wr_ready && !m_armed && exp_len < MAX) begin
      exp_b[exp_len] = b; exp_len++;
    end
    tick();
    wr_valid = 0;
  endtask

  task automatic arm();
    fw_arm = 1; tick(); fw_arm = 0; m_armed = 1;
  endtask

  task automatic send_in();
    tok_in = 1; tick(); tok_in = 0;
  endtask

  task automatic recv_pkt(input string req);
    int idx = 0;
    while (tx_valid) begin
      tx_ready = ($urandom % 4) != 0;
      #1;
      if (tx_ready) begin
        if (exp_len == 0) begin
          chk(tx_zlp && tx_last, "R5 zlp beat", {tx_zlp, tx_last}, 3);
        end else begin
          chk(tx_data == exp_b[idx], req, tx_data, exp_b[idx]);
          chk(tx_last == exp_last(idx, exp_len), "R3 last mark", tx_last,
              exp_last(idx, exp_len));
          idx++;
        end
        tick();
      end else begin
        logic [7:0] hd = tx_data;
        logic hl = tx_last;
        tick();
        chk(tx_valid && tx_data == hd && tx_last == hl, "R4 hold", tx_data, hd);
      end
    end
    tx_ready = 0;
    if (exp_len > 0) chk(idx == exp_len, "R3 beat count", idx, exp_len);
  endtask

  task automatic ack_pkt();
    hs_ack = 1; tick(); hs_ack = 0;
    m_armed = 0; exp_len = 0;
    chk(tx_done && !pkt_armed, "R6 ack done", {tx_done, pkt_armed}, 2);
  endtask

  task automatic clr_done();
    fw_clr_done = 1; tick(); fw_clr_done = 0;
    chk(!tx_done, "R8 clear", tx_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) tick();
    rst_n = 1; tick();
    // R1
    chk(!pkt_armed && !tx_done && !wr_err && !status_stage && !irq && !nak &&
        !tx_valid && wr_ready, "R1 reset", pkt_armed, 0);

    // R2: IN with nothing armed
    send_in();
    chk(nak && !tx_valid, "R2 nak", nak, 1);
    tick();
    chk(!nak, "R2 nak one cycle", nak, 0);

    // R11: full buffer plus extra byte
    for (int i = 0; i < MAX; i++) wr_byte(byte'(i * 3 + 1));
    chk(!wr_ready, "R11 full ready", wr_ready, 0);
    wr_byte(8'hEE);
    arm(); send_in();
    recv_pkt("R11 full data");
    ack_pkt();
    irq_en = 1; #1;
    chk(irq == exp_irq(tx_done, irq_en), "R9 irq on", irq, 1);
    irq_en = 0; #1;
    chk(irq == exp_irq(tx_done, irq_en), "R9 irq off", irq, 0);
    tick();
    chk(tx_done, "R8 sticky", tx_done, 1);
    clr_done();

    // R5: zero-length packet
    arm(); send_in();
    recv_pkt("R5 zlp");
    ack_pkt(); clr_done();

    // R10: writes while armed dropped
    for (int i = 0; i < 5; i++) wr_byte(byte'(8'h40 + i));
    arm();
    wr_byte(8'hAA);
    chk(wr_err, "R10 err set", wr_err, 1);
    send_in(); recv_pkt("R10 data unchanged");
    ack_pkt(); clr_done();

    // R3/R7: random packets with timeouts
    for (int n = 0; n < 40; n++) begin
      int len = $urandom % (MAX + 1);
      for (int i = 0; i < len; i++) wr_byte(byte'($urandom));
      arm(); send_in();
      recv_pkt("R3 data");
      if ($urandom % 3 == 0) begin
        hs_timeout = 1; tick(); hs_timeout = 0;
        chk(pkt_armed && !tx_done, "R7 timeout keep", {pkt_armed, tx_done}, 2);
        send_in(); recv_pkt("R7 resend");
      end
      ack_pkt(); clr_done();
    end

    // R13: setup in mid-send
    for (int i = 0; i < 10; i++) wr_byte(byte'(i));
    arm(); wr_byte(8'h11);
    send_in();
    tx_ready = 1; tick(); tx_ready = 0;
    tok_setup = 1; tick(); tok_setup = 0;
    m_armed = 0; exp_len = 0;
    chk(!tx_valid && !pkt_armed && !wr_err, "R13 flush", tx_valid, 0);
    send_in();
    chk(nak && !tx_valid, "R13 nak after setup", nak, 1);

    // R12: OUT token enters status stage
    tok_out = 1; tick(); tok_out = 0;
    chk(status_stage, "R12 status", status_stage, 1);
    send_in();
    chk(nak && !tx_valid, "R2 nak in status", nak, 1);
    tok_setup = 1; tick(); tok_setup = 0;
    chk(!status_stage, "R13 status cleared", status_stage, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule